// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block is the multiply unit of a processor execute stage. It takes two 32-bit operands, a 3-bit operation code, an optional 64-bit accumulator given as a high and a low word, and a start strobe. It returns a high and a low result word together with a one-cycle done pulse. Operations that keep only the low 32 bits finish in one or two cycles through a single-cycle low-word product. Operations that return 64 bits walk the second operand 8 bits per cycle and add one shifted partial product per step. They stop as soon as the bits not yet consumed are redundant: all zero for an unsigned operand, all equal to the last consumed bit for a signed one.

An interrupt can abandon an operation that is still running. It raises the abort input, the unit is free after the next clock edge, and the result words keep their earlier values. The execute stage then issues the same operation again from the start. The result registers change only in the cycle in which done is high, so a caller never sees a partial product.

Top module: `emt_multiplier`

## Requirements
- R1: Op codes 0 and 3 produce the low 32 bits of opa*opb on res_lo with res_hi = 0, and done is high in the cycle after the cycle in which start was sampled (latency 1).
- R2: Op code 1 gives res_lo = acc_lo + low(opa*opb) and op code 2 gives res_lo = acc_lo - low(opa*opb), both modulo 2^32, with res_hi = 0 and latency 2.
- R3: Op code 4 (unsigned) and op code 5 (signed) give the full 64-bit product of opa and opb, high word on res_hi and low word on res_lo.
- R4: Op code 6 (unsigned) and op code 7 (signed) give {acc_hi,acc_lo} plus the 64-bit product, modulo 2^64, on {res_hi,res_lo}.
- R5: For op codes 4 and 5 the latency is 1+n cycles. n is the smallest count of 8-bit groups, at least 2 and at most 4, such that opb fits in 8n bits (unsigned) or in 8n-bit two's complement (signed). The latency therefore lies between 3 and 5.
- R6: For op codes 6 and 7 the latency is one cycle more than for op codes 4 and 5 with the same opb, so it lies between 4 and 6.
- R7: busy is low after reset and stays low for the 1-cycle ops. For every other op it is high in each cycle from the one after start is sampled up to, but not including, the done cycle. When done is high, busy is low.
- R8: A start raised while busy is high is ignored: the running op's result and latency are unchanged.
- R9: When abort is high while busy is high, the next cycle shows busy low and done low, and res_hi/res_lo keep their previous values. This holds even when the abort coincides with the step that would have completed the op.
- R10: After an abort, a new start of the same op runs from the beginning and returns the correct result.
- R11: While reset is asserted, busy, done, res_hi and res_lo are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when the unit is not busy |
| op | input | 3 | Operation code (see R1 to R4) |
| opa | input | 32 | Multiplicand |
| opb | input | 32 | Multiplier, consumed 8 bits per step by long ops |
| acc_hi | input | 32 | Accumulator high word, sampled with start |
| acc_lo | input | 32 | Accumulator low word, sampled with start |
| abort | input | 1 | Abandon the running operation |
| busy | output | 1 | An operation is in flight |
| done | output | 1 | One-cycle pulse when results are written |
| res_hi | output | 32 | Result high word |
| res_lo | output | 32 | Result low word |

## Verification
Abort and completion can fall on the same clock edge: an abort raised in the cycle before the one where done would appear meets the final partial-product step or the final accumulate step. The bench starts each long op and each two-cycle op and raises abort on every busy cycle in turn, the last one included. After that edge it expects busy and done low and both result words equal to the value they held before the start, and then it reruns the op to confirm that the restart gives the correct result. A start raised during a busy cycle is provoked the same way, and the bench judges it by the result and latency of the op already in flight.

// File: rtl/emt_mult_pkg.sv
package emt_mult_pkg;

    typedef enum logic [2:0] {
        OP_MUL32   = 3'd0,
        OP_MAC32   = 3'd1,
        OP_MSB32   = 3'd2,
        OP_MUL32B  = 3'd3,
        OP_LMUL_U  = 3'd4,
        OP_LMUL_S  = 3'd5,
        OP_LMAC_U  = 3'd6,
        OP_LMAC_S  = 3'd7
    } mult_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SACC = 2'd1,
        ST_RUN  = 2'd2,
        ST_LACC = 2'd3
    } mult_st_e;

endpackage

// File: rtl/emt_lowprod.sv
// Single-cycle low-word product; low bits are the same for signed and unsigned.
module emt_lowprod #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] p_o
);
    assign p_o = a_i * b_i;
endmodule

// File: rtl/emt_chunk_pp.sv
// One partial product: extended multiplicand times one multiplier group,
// sign-extended to the full product width and aligned to its group position.
module emt_chunk_pp #(
    parameter int WIDTH = 32,
    parameter int CHUNK = 8,
    parameter int IDXW  = 2
) (
    input  logic [WIDTH:0]     a_ext_i,
    input  logic [CHUNK-1:0]   chunk_i,
    input  logic               chunk_signed_i,
    input  logic [IDXW-1:0]    idx_i,
    output logic [2*WIDTH-1:0] term_o
);
    localparam int PPW = WIDTH + CHUNK + 2;
    localparam int PW  = 2 * WIDTH;

    logic signed [WIDTH:0]  a_s;
    logic signed [CHUNK:0]  c_s;
    logic signed [PPW-1:0]  pp;
    logic        [PW-1:0]   ext;

    assign a_s    = a_ext_i;
    assign c_s    = {chunk_signed_i & chunk_i[CHUNK-1], chunk_i};
    assign pp     = a_s * c_s;
    assign ext    = {{(PW-PPW){pp[PPW-1]}}, pp};
    assign term_o = ext << (int'(idx_i) * CHUNK);
endmodule

// File: rtl/emt_term_detect.sv
// Decides whether the group at idx_i is the last one the product needs.
module emt_term_detect #(
    parameter int WIDTH      = 32,
    parameter int CHUNK      = 8,
    parameter int IDXW       = 2,
    parameter int MIN_CHUNKS = 2
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             sgn_i,
    input  logic [IDXW-1:0]  idx_i,
    output logic             last_o
);
    localparam int NCHUNK = WIDTH / CHUNK;

    logic [NCHUNK-1:0] redundant;

    for (genvar k = 0; k < NCHUNK - 1; k++) begin : g_bound
        localparam int LO = (k + 1) * CHUNK;
        logic [WIDTH-LO:0] upper_s;
        logic [WIDTH-LO-1:0] upper_u;
        assign upper_s      = b_i[WIDTH-1:LO-1];
        assign upper_u      = b_i[WIDTH-1:LO];
        assign redundant[k] = sgn_i ? ((&upper_s) | ~(|upper_s)) : ~(|upper_u);
    end
    assign redundant[NCHUNK-1] = 1'b1;

    assign last_o = (int'(idx_i) >= MIN_CHUNKS - 1) && redundant[idx_i];
endmodule

// File: rtl/emt_multiplier.sv
module emt_multiplier
    import emt_mult_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int CHUNK      = 8,
    parameter int MIN_CHUNKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] acc_hi,
    input  logic [WIDTH-1:0] acc_lo,
    input  logic             abort,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] res_hi,
    output logic [WIDTH-1:0] res_lo
);
    localparam int NCHUNK = WIDTH / CHUNK;
    localparam int IDXW   = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int PW     = 2 * WIDTH;

    typedef struct packed {
        mult_st_e          st;
        logic [IDXW-1:0]   idx;
        logic [WIDTH:0]    a_ext;
        logic [WIDTH-1:0]  b_q;
        logic              sgn;
        logic              accum;
        logic              sub;
        logic [PW-1:0]     acc_q;
        logic [PW-1:0]     prod;
        logic [WIDTH-1:0]  res_hi;
        logic [WIDTH-1:0]  res_lo;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [WIDTH-1:0] lowp;
    logic [PW-1:0]    term;
    logic [PW-1:0]    sum;
    logic [CHUNK-1:0] chunk;
    logic             last;
    logic             chunk_sgn;
    mult_op_e         op_v;

    assign op_v      = mult_op_e'(op);
    assign chunk     = r_q.b_q[int'(r_q.idx)*CHUNK +: CHUNK];
    assign chunk_sgn = r_q.sgn & last;
    assign sum       = r_q.prod + term;

    emt_lowprod #(.WIDTH(WIDTH)) u_lowp (
        .a_i (opa),
        .b_i (opb),
        .p_o (lowp)
    );

    emt_chunk_pp #(.WIDTH(WIDTH), .CHUNK(CHUNK), .IDXW(IDXW)) u_pp (
        .a_ext_i        (r_q.a_ext),
        .chunk_i        (chunk),
        .chunk_signed_i (chunk_sgn),
        .idx_i          (r_q.idx),
        .term_o         (term)
    );

    emt_term_detect #(.WIDTH(WIDTH), .CHUNK(CHUNK), .IDXW(IDXW),
                      .MIN_CHUNKS(MIN_CHUNKS)) u_term (
        .b_i    (r_q.b_q),
        .sgn_i  (r_q.sgn),
        .idx_i  (r_q.idx),
        .last_o (last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.acc_q = {acc_hi, acc_lo};
                    if (!op[2]) begin
                        if (op_v == OP_MAC32 || op_v == OP_MSB32) begin
                            r_d.st   = ST_SACC;
                            r_d.sub  = (op_v == OP_MSB32);
                            r_d.prod = {{WIDTH{1'b0}}, lowp};
                        end else begin
                            r_d.res_lo = lowp;
                            r_d.res_hi = '0;
                            r_d.done   = 1'b1;
                        end
                    end else begin
                        r_d.st    = ST_RUN;
                        r_d.idx   = '0;
                        r_d.sgn   = op[0];
                        r_d.accum = op[1];
                        r_d.a_ext = {op[0] & opa[WIDTH-1], opa};
                        r_d.b_q   = opb;
                        r_d.prod  = '0;
                    end
                end
            end
            ST_SACC: begin
                if (abort) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.res_lo = r_q.sub ? (r_q.acc_q[WIDTH-1:0] - r_q.prod[WIDTH-1:0])
                                         : (r_q.acc_q[WIDTH-1:0] + r_q.prod[WIDTH-1:0]);
                    r_d.res_hi = '0;
                    r_d.done   = 1'b1;
                    r_d.st     = ST_IDLE;
                end
            end
            ST_RUN: begin
                if (abort) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.prod = sum;
                    if (last) begin
                        if (r_q.accum) begin
                            r_d.st = ST_LACC;
                        end else begin
                            r_d.res_hi = sum[PW-1:WIDTH];
                            r_d.res_lo = sum[WIDTH-1:0];
                            r_d.done   = 1'b1;
                            r_d.st     = ST_IDLE;
                        end
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            ST_LACC: begin
                if (abort) begin
                    r_d.st = ST_IDLE;
                end else begin
                    {r_d.res_hi, r_d.res_lo} = r_q.prod + r_q.acc_q;
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy   = (r_q.st != ST_IDLE);
    assign done   = r_q.done;
    assign res_hi = r_q.res_hi;
    assign res_lo = r_q.res_lo;

    // Cycles spent busy, for the latency bound check.
    logic [2:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                lat_q <= '0;
        else if (r_q.st == ST_IDLE) lat_q <= '0;
        else                        lat_q <= lat_q + 3'd1;
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !abort |=> busy || done); // R7

    AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort |=> !busy && !done); // R9

    AST_NO_PARTIAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(res_hi) && $stable(res_lo)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.b_q) && $stable(r_q.a_ext) && $stable(r_q.acc_q)); // R8

    AST_LAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> lat_q < 3'd5); // R6

endmodule

// File: tb/emt_multiplier_tb_top.sv
module emt_multiplier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
    logic        abort = 1'b0;
    logic        busy, done;
    logic [31:0] res_hi, res_lo;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    emt_multiplier dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .abort(abort), .busy(busy), .done(done),
        .res_hi(res_hi), .res_lo(res_lo)
    );

    logic [31:0] vals [18];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_res(input logic [2:0] o, input logic [31:0] a,
                                            input logic [31:0] b, input logic [63:0] acc);
        logic [63:0] ea, eb, p;
        logic [31:0] lo, r;
        lo = a * b;
        case (o)
            3'd1: begin r = acc[31:0] + lo; return {32'h0, r}; end
            3'd2: begin r = acc[31:0] - lo; return {32'h0, r}; end
            3'd0, 3'd3: return {32'h0, lo};
            default: begin
                ea = o[0] ? {{32{a[31]}}, a} : {32'h0, a};
                eb = o[0] ? {{32{b[31]}}, b} : {32'h0, b};
                p  = ea * eb;
                if (o[1]) p = p + acc;
                return p;
            end
        endcase
    endfunction

    function automatic int ref_lat(input logic [2:0] o, input logic [31:0] b);
        int n;
        longint sb, lim;
        if (o == 3'd1 || o == 3'd2) return 2;
        if (!o[2]) return 1;
        n  = 4;
        sb = o[0] ? longint'($signed(b)) : longint'({32'h0, b});
        for (int k = 3; k >= 2; k--) begin
            lim = longint'(1) << (8 * k);
            if (o[0]) begin
                if (sb >= -(lim / 2) && sb < lim / 2) n = k;
            end else if (sb < lim) begin
                n = k;
            end
        end
        return 1 + n + (o[1] ? 1 : 0);
    endfunction

    function automatic string res_tag(input logic [2:0] o);
        if (o == 3'd0 || o == 3'd3) return "R1 result";
        if (!o[2])                  return "R2 result";
        if (!o[1])                  return "R3 result";
        return "R4 result";
    endfunction

    function automatic string lat_tag(input logic [2:0] o);
        if (o == 3'd0 || o == 3'd3) return "R1 latency";
        if (!o[2])                  return "R2 latency";
        if (!o[1])                  return "R5 latency";
        return "R6 latency";
    endfunction

    // Runs one op to completion; when spam is set a second start is raised
    // in the first busy cycle with different inputs.
    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                          input logic [63:0] acc, input bit spam, input string extra);
        int lat;
        bit busy_bad;
        logic [63:0] exp;
        @(negedge clk);
        op = o; opa = a; opb = b; {acc_hi, acc_lo} = acc; start = 1'b1;
        lat = 0; busy_bad = 1'b0;
        while (lat < 20) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (spam && lat == 1 && !done) begin
                op = ~o; opa = ~a; opb = b ^ 32'h5A5A_0F0F; {acc_hi, acc_lo} = ~acc;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
            if (!busy) busy_bad = 1'b1;
        end
        start = 1'b0;
        exp = ref_res(o, a, b, acc);
        chk({res_hi, res_lo} == exp, {spam ? "R8 " : "", extra, res_tag(o)},
            {res_hi, res_lo}, exp);
        chk(lat == ref_lat(o, b), {spam ? "R8 " : "", lat_tag(o)},
            64'(lat), 64'(ref_lat(o, b)));
        chk(!busy_bad && !busy, "R7 busy window", {63'h0, busy_bad}, 64'h0);
    endtask

    // Starts an op, raises abort in busy cycle j, checks the aftermath, reruns.
    task automatic abort_at(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                            input logic [63:0] acc, input int j);
        logic [63:0] prev;
        prev = {res_hi, res_lo};
        @(negedge clk);
        op = o; opa = a; opb = b; {acc_hi, acc_lo} = acc; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i < j; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(busy == 1'b1, "R9 busy before abort", {63'h0, busy}, 64'h1);
        abort = 1'b1;
        @(posedge clk);
        @(negedge clk);
        abort = 1'b0;
        chk(!busy && !done, "R9 free after abort", {62'h0, busy, done}, 64'h0);
        chk({res_hi, res_lo} == prev, "R9 result held", {res_hi, res_lo}, prev);
        @(posedge clk);
        @(negedge clk);
        chk(!done && {res_hi, res_lo} == prev, "R9 no late done", {res_hi, res_lo}, prev);
        run_op(o, a, b, acc, 1'b0, "R10 ");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            checks++;
            errs++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        vals = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_007F,
                 32'h0000_0080, 32'h0000_00FF, 32'h0000_0100, 32'h0000_7FFF,
                 32'h0000_8000, 32'hFFFF_8000, 32'h007F_FFFF, 32'h0080_0000,
                 32'hFF7F_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678,
                 32'hFFFF_FF80, 32'hDEAD_BEEF};

        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !done && res_hi == 0 && res_lo == 0, "R11 reset state",
            {res_hi, res_lo}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Main sweep over all op codes and operand patterns (R1..R7).
        for (int o = 0; o < 8; o++) begin
            for (int ia = 0; ia < 18; ia++) begin
                for (int ib = 0; ib < 18; ib++) begin
                    run_op(3'(o), vals[ia], vals[ib],
                           {vals[(ia + ib) % 18], vals[(ia * 3 + 1) % 18]}, 1'b0, "");
                end
            end
        end

        // R8: start raised while busy for long ops.
        for (int o = 4; o < 8; o++) begin
            for (int ib = 0; ib < 18; ib++) begin
                run_op(3'(o), vals[(ib + 5) % 18], vals[ib],
                       {vals[ib], vals[(ib + 7) % 18]}, 1'b1, "");
            end
        end

        // R9 and R10: abort in every busy cycle, the completing one included.
        for (int o = 1; o < 8; o++) begin
            if (o == 3) continue;
            for (int ib = 0; ib < 18; ib += 3) begin
                for (int j = 1; j < ref_lat(3'(o), vals[ib]); j++) begin
                    abort_at(3'(o), vals[(ib + 11) % 18], vals[ib],
                             {vals[(ib + 2) % 18], vals[(ib + 9) % 18]}, j);
                end
            end
        end

        // Back-to-back 1-cycle ops (R1).
        for (int i = 0; i < 18; i++) begin
            run_op(3'd0, vals[i], vals[17 - i], 64'h0, 1'b0, "");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule